// File: doc/BRIEF.md
# Per-CPU Device Interrupt Masking Router

This block gathers up to 64 device interrupt request lines into one shared pending vector and steers them to up to four processors. Devices report a line going up or going down with a one-cycle event pulse and a line number. Each processor owns a writable 64-bit enable mask. The enabled pending vector for that processor is its mask ANDed with the shared pending vector, and software can read it back.

The block drives one level interrupt per processor. That output is high while any enabled pending bit of the processor is set. A mask write takes effect on the outputs on the next clock edge. If a line event arrives in the same cycle as a mask write, both are applied.

Software reaches the registers through a simple 64-bit register port. Registers are placed 64 bytes apart. Only full 64-bit accesses are accepted; any other access, or any unsupported access, returns an error.

Top module: `irq_mask_router`

## Requirements
- R1: After reset, every mask, the pending vector, `irq_o`, `rsp_valid_o`, `rsp_err_o` and `rsp_rdata_o` are zero.
- R2: A pulse on `line_set_i` sets pending bit `line_set_idx_i`. A pulse on `line_clr_i` clears pending bit `line_clr_idx_i`. Clearing a line that is not pending has no effect. If a set and a clear name the same line in the same cycle, the set wins.
- R3: Register index 0..3 is the mask of CPU 0..3. It can be read and written with 64-bit accesses.
- R4: Register index 4..7 reads as mask AND pending for CPU 0..3.
- R5: Register index 8 reads as the pending vector.
- R6: `irq_o[c]` is a register that, on each clock edge, takes the OR of CPU c's updated mask ANDed with the updated pending vector. A mask write or a line event therefore shows on `irq_o` one cycle later, both when it posts an interrupt and when it retracts one.
- R7: A mask write and a line event in the same cycle are both applied.
- R8: `req_size_i` encodes 0=8-bit, 1=16-bit, 2=32-bit, 3=64-bit. Any size other than 3 gives an error response with zero read data and changes no state.
- R9: A write to index 4..8, or any access to an index above 8, gives an error response with zero read data and changes no state.
- R10: Every request (`req_valid_i` high) gets exactly one response on the next cycle: `rsp_valid_o`, `rsp_err_o` and `rsp_rdata_o` are registered.
- R11: The register index is `req_addr_i >> 6`. Offset bits [5:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset from the block base |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_err_o | output | 1 | Access rejected |
| rsp_rdata_o | output | DATA_W | Read data |
| line_set_i | input | 1 | Device line raise event |
| line_set_idx_i | input | LINE_W | Line being raised |
| line_clr_i | input | 1 | Device line lower event |
| line_clr_idx_i | input | LINE_W | Line being lowered |
| irq_o | output | NUM_CPUS | Level interrupt per processor |

## Verification
The bench builds the block with its default parameters: four CPUs, 64 lines, a 64-bit data path and a 12-bit offset. With these values it can drive the top line (bit 63) and the lowest line together with every CPU slice, including CPU 3. The register index field is 6 bits wide, so the bench can also hit indices above the last mapped register, and it can set low offset bits to show that they are ignored.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned MAX_CPUS  = 4;
  localparam int unsigned MASK_BASE = 0;
  localparam int unsigned ACT_BASE  = 4;
  localparam int unsigned RAW_IDX   = 8;
  localparam int unsigned IDX_SHIFT = 6;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} acc_size_e;
  typedef enum logic [1:0] {K_NONE, K_MASK, K_ACT, K_RAW} reg_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned IDX_W    = 6,
  localparam int unsigned CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [1:0]       size_i,
  input  logic [IDX_W-1:0] idx_i,
  output reg_kind_e        kind_o,
  output logic [CPU_W-1:0] cpu_o,
  output logic             err_o,
  output logic [NUM_CPUS-1:0] mask_we_o
);
  always_comb begin
    kind_o = K_NONE;
    cpu_o  = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (idx_i == IDX_W'(MASK_BASE + c)) begin
        kind_o = K_MASK;
        cpu_o  = CPU_W'(c);
      end
      if (idx_i == IDX_W'(ACT_BASE + c)) begin
        kind_o = K_ACT;
        cpu_o  = CPU_W'(c);
      end
    end
    if (idx_i == IDX_W'(RAW_IDX)) kind_o = K_RAW;
  end

  logic size_ok;
  assign size_ok = (size_i == SZ_64);
  assign err_o   = valid_i && (!size_ok || kind_o == K_NONE || (write_i && kind_o != K_MASK));

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++)
      mask_we_o[c] = valid_i && write_i && !err_o && kind_o == K_MASK && cpu_o == CPU_W'(c);
  end
endmodule

// File: rtl/irq_raw_vec.sv
module irq_raw_vec #(
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [LINE_W-1:0]    set_idx_i,
  input  logic                 clr_i,
  input  logic [LINE_W-1:0]    clr_idx_i,
  output logic [NUM_LINES-1:0] raw_next_o,
  output logic [NUM_LINES-1:0] raw_q_o
);
  // clear first, so a same-line set in the same cycle wins
  always_comb begin
    raw_next_o = raw_q_o;
    if (clr_i) raw_next_o[clr_idx_i] = 1'b0;
    if (set_i) raw_next_o[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q_o <= '0;
    else         raw_q_o <= raw_next_o;
  end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] raw_q_i,
  input  logic [NUM_LINES-1:0] raw_next_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] active_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] mask_next;

  assign mask_next = we_i ? wdata_i : mask_o;
  assign active_o  = mask_o & raw_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_o <= mask_next;
      irq_o  <= |(mask_next & raw_next_i);
    end
  end
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPUS  = 4,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned IDX_W    = ADDR_W - IDX_SHIFT,
  localparam int unsigned CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [1:0]          req_size_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic                rsp_err_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  input  logic                line_set_i,
  input  logic [LINE_W-1:0]   line_set_idx_i,
  input  logic                line_clr_i,
  input  logic [LINE_W-1:0]   line_clr_idx_i,
  output logic [NUM_CPUS-1:0] irq_o
);
  reg_kind_e            kind;
  logic [CPU_W-1:0]     cpu_sel;
  logic                 dec_err;
  logic [NUM_CPUS-1:0]  mask_we;
  logic [IDX_W-1:0]     reg_idx;
  logic                 unused_low;

  logic [NUM_LINES-1:0] raw_q, raw_next;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_all, active_all;

  assign reg_idx    = req_addr_i[ADDR_W-1:IDX_SHIFT];
  assign unused_low = ^req_addr_i[IDX_SHIFT-1:0];

  irq_reg_decode #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W)) i_decode (
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .size_i    (req_size_i),
    .idx_i     (reg_idx),
    .kind_o    (kind),
    .cpu_o     (cpu_sel),
    .err_o     (dec_err),
    .mask_we_o (mask_we)
  );

  irq_raw_vec #(.NUM_LINES(NUM_LINES)) i_raw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (line_set_i),
    .set_idx_i  (line_set_idx_i),
    .clr_i      (line_clr_i),
    .clr_idx_i  (line_clr_idx_i),
    .raw_next_o (raw_next),
    .raw_q_o    (raw_q)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_cpu_slice #(.NUM_LINES(NUM_LINES)) i_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (mask_we[c]),
      .wdata_i    (req_wdata_i[NUM_LINES-1:0]),
      .raw_q_i    (raw_q),
      .raw_next_i (raw_next),
      .mask_o     (mask_all[c]),
      .active_o   (active_all[c]),
      .irq_o      (irq_o[c])
    );
  end

  logic [DATA_W-1:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (!dec_err && !req_write_i) begin
      unique case (kind)
        K_MASK:  rdata_d = DATA_W'(mask_all[cpu_sel]);
        K_ACT:   rdata_d = DATA_W'(active_all[cpu_sel]);
        K_RAW:   rdata_d = DATA_W'(raw_q);
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && dec_err;
      rsp_rdata_o <= req_valid_i ? rdata_d : '0;
    end
  end
endmodule

// File: rtl/irq_mask_router_chk.sv
module irq_mask_router_chk #(
  parameter int unsigned NUM_CPUS  = 4,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned LINE_W    = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic [1:0]          req_size_i,
  input logic                rsp_valid_o,
  input logic                rsp_err_o,
  input logic                line_set_i,
  input logic [LINE_W-1:0]   line_set_idx_i,
  input logic                line_clr_i,
  input logic [LINE_W-1:0]   line_clr_idx_i,
  input logic [NUM_CPUS-1:0] irq_o,
  input logic [NUM_LINES-1:0] raw_q,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_all
);
  p_rsp_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_spurious_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_bad_size_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != 2'd3) |=> rsp_err_o);
  p_bad_size_keeps_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != 2'd3) |=> $stable(mask_all));
  p_line_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_set_i |=> raw_q[$past(line_set_idx_i)]);
  p_line_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_clr_i && !(line_set_i && line_set_idx_i == line_clr_idx_i))
      |=> !raw_q[$past(line_clr_idx_i)]);
  p_quiet_when_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q == '0) |-> (irq_o == '0));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu_chk
    p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] == |(mask_all[c] & raw_q));
  end
endmodule

bind irq_mask_router irq_mask_router_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_size_i     (req_size_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_err_o      (rsp_err_o),
  .line_set_i     (line_set_i),
  .line_set_idx_i (line_set_idx_i),
  .line_clr_i     (line_clr_i),
  .line_clr_idx_i (line_clr_idx_i),
  .irq_o          (irq_o),
  .raw_q          (raw_q),
  .mask_all       (mask_all)
);

// File: tb/test_irq_mask_router.sv
module test_irq_mask_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'd3;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic line_set = 0, line_clr = 0;
  logic [5:0] line_set_idx = '0, line_clr_idx = '0;
  logic [3:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m [4];
  logic [63:0] raw;

  always #4 clk = ~clk;

  irq_mask_router i_irq_mask_router (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .line_set_i(line_set), .line_set_idx_i(line_set_idx),
    .line_clr_i(line_clr), .line_clr_idx_i(line_clr_idx),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = |(m[c] & raw);
    return r;
  endfunction

  // one request and/or line event, response sampled one cycle later
  task automatic cyc(input logic v, input logic w, input logic [5:0] idx, input logic [5:0] low,
                     input logic [1:0] sz, input logic [63:0] wd,
                     input logic ls, input logic [5:0] lsi, input logic lc, input logic [5:0] lci,
                     output logic [63:0] rd, output logic e);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = {idx, low}; req_size = sz; req_wdata = wd;
    line_set = ls; line_set_idx = lsi; line_clr = lc; line_clr_idx = lci;
    @(negedge clk);
    rd = rsp_rdata; e = rsp_err;
    if (v) chk("R10 response valid", {63'd0, rsp_valid}, 64'd1);
    req_valid = 0; req_write = 0; line_set = 0; line_clr = 0; req_size = 2'd3;
  endtask

  task automatic reg_wr(input logic [5:0] idx, input logic [63:0] d, output logic e);
    logic [63:0] rd;
    cyc(1, 1, idx, 6'd0, 2'd3, d, 0, 0, 0, 0, rd, e);
  endtask

  task automatic reg_rd(input logic [5:0] idx, output logic [63:0] d, output logic e);
    cyc(1, 0, idx, 6'd0, 2'd3, '0, 0, 0, 0, 0, d, e);
  endtask

  task automatic line_ev(input logic ls, input logic [5:0] lsi, input logic lc, input logic [5:0] lci);
    logic [63:0] rd; logic e;
    cyc(0, 0, 0, 0, 2'd3, '0, ls, lsi, lc, lci, rd, e);
    if (lc) raw[lci] = 1'b0;
    if (ls) raw[lsi] = 1'b1;
    chk("R6 irq after line event", {60'd0, irq}, {60'd0, exp_irq()});
  endtask

  task automatic t_reset();
    logic [63:0] d; logic e;
    chk("R1 irq at reset", {60'd0, irq}, 64'd0);
    chk("R1 rsp_valid at reset", {63'd0, rsp_valid}, 64'd0);
    chk("R1 rdata at reset", rsp_rdata, 64'd0);
    for (int c = 0; c < 4; c++) begin
      reg_rd(6'(c), d, e);
      chk("R1 mask zero", d, 64'd0);
    end
    reg_rd(6'd8, d, e);
    chk("R1 pending zero", d, 64'd0);
  endtask

  task automatic t_mask_rw();
    logic [63:0] d; logic e;
    m[0] = 64'h0000_0000_0000_0001;
    m[1] = 64'h8000_0000_0000_0000;
    m[2] = 64'h0000_00F0_0000_0080;
    m[3] = 64'hA5A5_5A5A_0F0F_F0F0;
    for (int c = 0; c < 3; c++) begin
      reg_wr(6'(c), m[c], e);
      chk("R3 mask write ok", {63'd0, e}, 64'd0);
    end
    // mask 3 written with nonzero offset bits
    cyc(1, 1, 6'd3, 6'h2B, 2'd3, m[3], 0, 0, 0, 0, d, e);
    chk("R11 write with low offset bits", {63'd0, e}, 64'd0);
    for (int c = 0; c < 4; c++) begin
      reg_rd(6'(c), d, e);
      chk("R3 mask readback", d, m[c]);
    end
    cyc(1, 0, 6'd2, 6'h3F, 2'd3, '0, 0, 0, 0, 0, d, e);
    chk("R11 read with low offset bits", d, m[2]);
    chk("R6 no irq with empty pending", {60'd0, irq}, 64'd0);
  endtask

  task automatic t_lines();
    logic [63:0] d; logic e;
    line_ev(1, 6'd0, 0, 0);
    reg_rd(6'd8, d, e);
    chk("R2 R5 set line 0", d, raw);
    line_ev(1, 6'd63, 0, 0);
    reg_rd(6'd8, d, e);
    chk("R2 R5 set line 63", d, 64'h8000_0000_0000_0001);
    line_ev(0, 0, 1, 6'd5);
    reg_rd(6'd8, d, e);
    chk("R2 spurious clear ignored", d, 64'h8000_0000_0000_0001);
    line_ev(1, 6'd7, 1, 6'd7);
    reg_rd(6'd8, d, e);
    chk("R2 same-line set wins", d, 64'h8000_0000_0000_0081);
    line_ev(0, 0, 1, 6'd7);
    reg_rd(6'd8, d, e);
    chk("R2 clear line 7", d, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_active();
    logic [63:0] d; logic e;
    line_ev(1, 6'd4, 0, 0);
    for (int c = 0; c < 4; c++) begin
      reg_rd(6'(4 + c), d, e);
      chk("R4 active vector", d, m[c] & raw);
    end
  endtask

  task automatic t_mask_irq();
    logic e;
    for (int c = 0; c < 4; c++) begin
      m[c] = '0;
      reg_wr(6'(c), '0, e);
    end
    chk("R6 retract after mask clear", {60'd0, irq}, 64'd0);
    m[2] = 64'h1;
    reg_wr(6'd2, m[2], e);
    chk("R6 post on mask write", {60'd0, irq}, 64'h4);
    m[3] = 64'h8000_0000_0000_0000;
    reg_wr(6'd3, m[3], e);
    chk("R6 post on line 63 for CPU 3", {60'd0, irq}, 64'hC);
    m[2] = 64'h2;
    reg_wr(6'd2, m[2], e);
    chk("R6 retract on mask change", {60'd0, irq}, 64'h8);
  endtask

  task automatic t_same_cycle();
    logic [63:0] d; logic e;
    cyc(1, 1, 6'd1, 6'd0, 2'd3, 64'h100, 1, 6'd8, 0, 0, d, e);
    m[1] = 64'h100; raw[8] = 1'b1;
    chk("R7 mask write with line set", {60'd0, irq}, {60'd0, exp_irq()});
    reg_rd(6'd5, d, e);
    chk("R7 active after combined update", d, 64'h100);
    cyc(1, 1, 6'd1, 6'd0, 2'd3, 64'h0, 1, 6'd9, 0, 0, d, e);
    m[1] = 64'h0; raw[9] = 1'b1;
    reg_rd(6'd8, d, e);
    chk("R7 line set kept with mask write", d, raw);
    chk("R7 irq after combined update", {60'd0, irq}, {60'd0, exp_irq()});
  endtask

  task automatic t_errors();
    logic [63:0] d; logic e;
    cyc(1, 1, 6'd0, 6'd0, 2'd2, 64'hFFFF, 0, 0, 0, 0, d, e);
    chk("R8 32-bit write error", {63'd0, e}, 64'd1);
    reg_rd(6'd0, d, e);
    chk("R8 mask unchanged", d, m[0]);
    cyc(1, 0, 6'd3, 6'd0, 2'd0, '0, 0, 0, 0, 0, d, e);
    chk("R8 8-bit read error", {63'd0, e}, 64'd1);
    chk("R8 8-bit read data zero", d, 64'd0);
    cyc(1, 0, 6'd3, 6'd0, 2'd1, '0, 0, 0, 0, 0, d, e);
    chk("R8 16-bit read error", {63'd0, e}, 64'd1);
    reg_wr(6'd5, 64'hFFFF_FFFF_FFFF_FFFF, e);
    chk("R9 active write error", {63'd0, e}, 64'd1);
    reg_rd(6'd1, d, e);
    chk("R9 mask untouched by active write", d, m[1]);
    reg_wr(6'd8, 64'd0, e);
    chk("R9 pending write error", {63'd0, e}, 64'd1);
    reg_rd(6'd8, d, e);
    chk("R9 pending unchanged", d, raw);
    reg_rd(6'd12, d, e);
    chk("R9 unmapped read error", {63'd0, e}, 64'd1);
    chk("R9 unmapped read data zero", d, 64'd0);
    chk("R9 irq unchanged", {60'd0, irq}, {60'd0, exp_irq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) m[c] = '0;
    raw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask_rw();
    t_lines();
    t_active();
    t_mask_irq();
    t_same_cycle();
    t_errors();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule